// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block turns every bus address into at most one active-low chip-select strobe. Eight channels each hold a programmed base and a qualifier word. A channel selects when the upper sixteen address bits match its base, with any bit its mask marks ignored. The access must also pass that channel's write-protect check, its access-space filter and its enable bit. Because masked bits may sit anywhere in the field, one channel can cover several separate blocks of the same size.

The decode is purely combinational from the current address and access attributes, so a bus controller can use the strobes in the same cycle it presents the address. A small synchronous configuration port writes the base and qualifier words, and a combinational read port returns them. Channel 0 starts out as a catch-all select after reset so that boot code can be fetched before any channel has been programmed. The lowest-numbered matching channel wins when regions overlap.

Top module: `csel_decoder`

## Requirements
- R1: After reset, every base and qualifier word reads as zero, so every enable bit is clear.
- R2: A write with `cfg_we` high updates channel `cfg_ch` at the next rising clock edge: the qualifier word when `cfg_is_mask` is 1, otherwise the base word. Nothing changes while `cfg_we` is low. The read port returns the selected word combinationally.
- R3: Base word layout: bits 31–16 hold the base and bits 15–0 read as zero. Qualifier layout: bits 31–16 are the address mask, bit 8 is write protect, bit 6 is the alternate-master enable, bits 5..1 mask the CPU/interrupt-acknowledge, supervisor code, supervisor data, user code and user data spaces in that order, and bit 0 is enable. Bits 15–9 and bit 7 ignore writes and read as zero.
- R4: Address bit 16+i takes part in the compare only when mask bit 16+i is 0. When the mask bit is 1, that address bit is ignored.
- R5: A channel with k mask bits set covers 2^(16+k) bytes. A lone higher mask bit yields separate blocks: base 0x0000 with mask 0x0008 selects upper addresses 0x0000 and 0x0008 and nothing in between.
- R6: With write protect set, a write (`bus_write`=1) never asserts that channel. Reads still do.
- R7: `acc_type` encodes 0 = CPU space/interrupt acknowledge, 1 = supervisor code, 2 = supervisor data, 3 = user code, 4 = user data. A set space-mask bit for the current type blocks the channel.
- R8: When `alt_master` is 1 and the channel's alternate-master enable is 0, the four supervisor/user space masks are ignored. The CPU-space mask still applies.
- R9: Channels 1 to 7 never assert while their enable bit is 0, whatever their other fields hold.
- R10: While channel 0's enable bit is 0, channel 0 asserts for every access and all other selects stay high. Once enabled, channel 0 decodes like the others.
- R11: Selects are active-low and at most one is low: the lowest-numbered channel that matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_is_mask | input | 1 | Write target: 1 = qualifier word, 0 = base word |
| cfg_ch | input | 3 | Channel written |
| cfg_wdata | input | 32 | Write data |
| cfg_rd_is_mask | input | 1 | Read target: 1 = qualifier word, 0 = base word |
| cfg_rd_ch | input | 3 | Channel read |
| cfg_rdata | output | 32 | Read data |
| bus_addr | input | 32 | Current bus address |
| bus_write | input | 1 | 1 = write access, 0 = read |
| acc_type | input | 3 | Access space, encoded as in R7 |
| alt_master | input | 1 | Access comes from an external master or DMA |
| cs_n | output | 8 | Active-low chip selects, one per channel |

## Verification
The assertions take for granted that `acc_type` carries only the five defined codes 0 to 4. They also assume that bus attributes are stable whenever the clock rises. The bench drives only those five codes, changes inputs away from the edges, and sweeps every legal type with both directions and both master kinds. It does this over a 128-entry window of address bits 22..16, which holds every programmed region, and repeats the window with the bits above set. Expected selects come from an arithmetic model of the requirements applied to the words the bench itself wrote.

// File: rtl/csel_pkg.sv
`timescale 1ns/1ps
package csel_pkg;

  localparam int REG_W = 32;
  localparam int FLD_W = 16;
  localparam int SPC_W = 5;

  typedef enum logic [2:0] {
    ACC_CPU      = 3'd0,
    ACC_SUP_CODE = 3'd1,
    ACC_SUP_DATA = 3'd2,
    ACC_USR_CODE = 3'd3,
    ACC_USR_DATA = 3'd4
  } csel_acc_e;

  // spc[4] = cpu/iack, spc[3] = sup code, spc[2] = sup data,
  // spc[1] = user code, spc[0] = user data
  typedef struct packed {
    logic [FLD_W-1:0] bam;
    logic             wp;
    logic             am;
    logic [SPC_W-1:0] spc;
    logic             vld;
  } csel_mask_t;

  function automatic csel_mask_t unpack_mask(input logic [REG_W-1:0] w);
    csel_mask_t m;
    m.bam = w[REG_W-1 -: FLD_W];
    m.wp  = w[8];
    m.am  = w[6];
    m.spc = w[5:1];
    m.vld = w[0];
    return m;
  endfunction

  function automatic logic [REG_W-1:0] pack_mask(input csel_mask_t m);
    logic [REG_W-1:0] w;
    w = '0;
    w[REG_W-1 -: FLD_W] = m.bam;
    w[8]   = m.wp;
    w[6]   = m.am;
    w[5:1] = m.spc;
    w[0]   = m.vld;
    return w;
  endfunction

endpackage

// File: rtl/csel_rst_sync.sv
`timescale 1ns/1ps
module csel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/csel_regfile.sv
`timescale 1ns/1ps
module csel_regfile
  import csel_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic                             cfg_is_mask,
  input  logic [CH_W-1:0]                  cfg_ch,
  input  logic [REG_W-1:0]                 cfg_wdata,
  input  logic                             cfg_rd_is_mask,
  input  logic [CH_W-1:0]                  cfg_rd_ch,
  output logic [REG_W-1:0]                 cfg_rdata,
  output logic [NUM_CH-1:0][FLD_W-1:0]     base_q,
  output csel_mask_t [NUM_CH-1:0]          mask_q
);

  logic [NUM_CH-1:0][FLD_W-1:0] base_d;
  csel_mask_t [NUM_CH-1:0]      mask_d;
  logic                         cfg_unused_bits;

  assign cfg_unused_bits = ^{cfg_wdata[REG_W-FLD_W-1:9], cfg_wdata[7]};

  always_comb begin
    base_d = base_q;
    mask_d = mask_q;
    if (cfg_is_mask) begin
      mask_d[cfg_ch] = unpack_mask(cfg_wdata);
    end else begin
      base_d[cfg_ch] = cfg_wdata[REG_W-1 -: FLD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
    end else if (cfg_we) begin
      base_q <= base_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    if (cfg_rd_is_mask) begin
      cfg_rdata = pack_mask(mask_q[cfg_rd_ch]);
    end else begin
      cfg_rdata = {base_q[cfg_rd_ch], {(REG_W-FLD_W){1'b0}}};
    end
  end

  AST_HOLD_WITHOUT_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(base_q) && $stable(mask_q))); // R2

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_is_mask) |=> (base_q[$past(cfg_ch)] == $past(cfg_wdata[REG_W-1 -: FLD_W]))); // R2

endmodule

// File: rtl/csel_chan_match.sv
`timescale 1ns/1ps
module csel_chan_match
  import csel_pkg::*;
#(
  parameter bit IS_GLOBAL = 1'b0
) (
  input  logic [FLD_W-1:0] addr_hi,
  input  logic             bus_write,
  input  logic [2:0]       acc_type,
  input  logic             alt_master,
  input  logic [FLD_W-1:0] base,
  input  csel_mask_t       mask,
  output logic             hit
);

  logic addr_ok;
  logic wp_blk;
  logic spc_bit;
  logic spc_ovr;
  logic spc_blk;
  logic decode;

  always_comb begin
    addr_ok = (((addr_hi ^ base) & ~mask.bam) == '0);
    wp_blk  = mask.wp & bus_write;
    case (acc_type)
      ACC_CPU:      spc_bit = mask.spc[4];
      ACC_SUP_CODE: spc_bit = mask.spc[3];
      ACC_SUP_DATA: spc_bit = mask.spc[2];
      ACC_USR_CODE: spc_bit = mask.spc[1];
      ACC_USR_DATA: spc_bit = mask.spc[0];
      default:      spc_bit = 1'b1;
    endcase
    spc_ovr = alt_master & ~mask.am & (acc_type != ACC_CPU);
    spc_blk = spc_bit & ~spc_ovr;
    decode  = addr_ok & ~wp_blk & ~spc_blk;
  end

  generate
    if (IS_GLOBAL) begin : g_global
      assign hit = ~mask.vld | decode;
    end else begin : g_normal
      assign hit = mask.vld & decode;
    end
  endgenerate

endmodule

// File: rtl/csel_prio.sv
`timescale 1ns/1ps
module csel_prio #(
  parameter int NUM_CH = 8
) (
  input  logic [NUM_CH-1:0] hit,
  output logic [NUM_CH-1:0] sel_n
);

  logic [NUM_CH-1:0] taken;
  logic [NUM_CH-1:0] grant;

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chain
      if (i == 0) begin : g_first
        assign taken[i] = 1'b0;
      end else begin : g_rest
        assign taken[i] = taken[i-1] | hit[i-1];
      end
      assign grant[i] = hit[i] & ~taken[i];
    end
  endgenerate

  assign sel_n = ~grant;

endmodule

// File: rtl/csel_decoder.sv
`timescale 1ns/1ps
module csel_decoder
  import csel_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int SYNC_STG  = 2,
  localparam int CH_W     = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_is_mask,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              cfg_rd_is_mask,
  input  logic [CH_W-1:0]   cfg_rd_ch,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic [REG_W-1:0]  bus_addr,
  input  logic              bus_write,
  input  logic [2:0]        acc_type,
  input  logic              alt_master,
  output logic [NUM_CH-1:0] cs_n
);

  logic                         rst_sync_n;
  logic [NUM_CH-1:0][FLD_W-1:0] base_q;
  csel_mask_t [NUM_CH-1:0]      mask_q;
  logic [NUM_CH-1:0]            hit;
  logic [FLD_W-1:0]             addr_hi;
  logic                         addr_unused_bits;

  assign addr_hi          = bus_addr[REG_W-1 -: FLD_W];
  assign addr_unused_bits = ^bus_addr[REG_W-FLD_W-1:0];

  csel_rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  csel_regfile #(.NUM_CH(NUM_CH)) u_regs (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .cfg_we         (cfg_we),
    .cfg_is_mask    (cfg_is_mask),
    .cfg_ch         (cfg_ch),
    .cfg_wdata      (cfg_wdata),
    .cfg_rd_is_mask (cfg_rd_is_mask),
    .cfg_rd_ch      (cfg_rd_ch),
    .cfg_rdata      (cfg_rdata),
    .base_q         (base_q),
    .mask_q         (mask_q)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      csel_chan_match #(.IS_GLOBAL(c == 0)) u_match (
        .addr_hi    (addr_hi),
        .bus_write  (bus_write),
        .acc_type   (acc_type),
        .alt_master (alt_master),
        .base       (base_q[c]),
        .mask       (mask_q[c]),
        .hit        (hit[c])
      );

      if (c > 0) begin : g_vld_chk
        AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
          !mask_q[c].vld |-> cs_n[c]); // R9
      end

      AST_WP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (bus_write && mask_q[c].wp && mask_q[c].vld) |-> cs_n[c]); // R6
    end
  endgenerate

  csel_prio #(.NUM_CH(NUM_CH)) u_prio (
    .hit   (hit),
    .sel_n (cs_n)
  );

  AST_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(~cs_n)); // R11

  AST_SEL_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((~cs_n & ~hit) == '0)); // R11

  AST_GLOBAL_BOOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mask_q[0].vld |-> (cs_n == {{(NUM_CH-1){1'b1}}, 1'b0})); // R10

  AST_TYPE_LEGAL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_type <= 3'd4)); // R7

endmodule

// File: tb/csel_decoder_tb.sv
`timescale 1ns/1ps
module csel_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic        cfg_is_mask;
  logic [2:0]  cfg_ch;
  logic [31:0] cfg_wdata;
  logic        cfg_rd_is_mask;
  logic [2:0]  cfg_rd_ch;
  logic [31:0] cfg_rdata;
  logic [31:0] bus_addr;
  logic        bus_write;
  logic [2:0]  acc_type;
  logic        alt_master;
  logic [7:0]  cs_n;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  logic [15:0] mdl_base [8];
  logic [31:0] mdl_mask [8];

  always #2.5 clk = ~clk;

  csel_decoder u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_we         (cfg_we),
    .cfg_is_mask    (cfg_is_mask),
    .cfg_ch         (cfg_ch),
    .cfg_wdata      (cfg_wdata),
    .cfg_rd_is_mask (cfg_rd_is_mask),
    .cfg_rd_ch      (cfg_rd_ch),
    .cfg_rdata      (cfg_rdata),
    .bus_addr       (bus_addr),
    .bus_write      (bus_write),
    .acc_type       (acc_type),
    .alt_master     (alt_master),
    .cs_n           (cs_n)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] qual(input logic [15:0] bam, input logic wp,
                                       input logic am, input logic [4:0] spc, input logic v);
    return {bam, 7'b0, wp, 1'b0, am, spc, v};
  endfunction

  // R3: stored images after the reserved bits are dropped
  task automatic cfg_write(input int ch, input logic is_mask, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_is_mask = is_mask; cfg_ch = 3'(ch); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    if (is_mask) mdl_mask[ch] = data & 32'hFFFF_017F;
    else         mdl_base[ch] = data[31:16];
  endtask

  task automatic read_check(input string tag, input int ch, input logic is_mask, input logic [31:0] exp);
    cfg_rd_ch = 3'(ch); cfg_rd_is_mask = is_mask;
    #1;
    check(tag, cfg_rdata, exp);
  endtask

  function automatic logic [7:0] ref_cs(input logic [15:0] ahi, input logic wr,
                                        input int typ, input logic alt);
    logic [7:0] r;
    bit got;
    r = 8'hFF; got = 1'b0;
    for (int c = 0; c < 8; c++) begin
      logic [31:0] m;
      logic h;
      m = mdl_mask[c];
      h = (((ahi ^ mdl_base[c]) & ~m[31:16]) == 16'h0)
          && !(m[8] && wr)
          && !(m[5-typ] && !(alt && !m[6] && typ != 0))
          && m[0];
      if (c == 0 && !m[0]) h = 1'b1;
      if (h && !got) begin r[c] = 1'b0; got = 1'b1; end
    end
    return r;
  endfunction

  task automatic sweep(input string tag, input bit full);
    for (int hi = 0; hi < (full ? 2 : 1); hi++) begin
      for (int lo = 0; lo < 128; lo++) begin
        for (int wr = 0; wr < (full ? 2 : 1); wr++) begin
          for (int typ = 0; typ < 5; typ++) begin
            for (int alt = 0; alt < 2; alt++) begin
              logic [15:0] ahi;
              ahi = {(hi != 0) ? 9'h155 : 9'h000, 7'(lo)};
              bus_addr   = {ahi, 16'(lo * 977)};
              bus_write  = 1'(wr);
              acc_type   = 3'(typ);
              alt_master = 1'(alt);
              #1;
              check(tag, {24'h0, cs_n}, {24'h0, ref_cs(ahi, 1'(wr), typ, 1'(alt))});
            end
          end
        end
      end
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !finished) begin
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_is_mask = 1'b0; cfg_ch = '0; cfg_wdata = '0;
    cfg_rd_is_mask = 1'b0; cfg_rd_ch = '0;
    bus_addr = '0; bus_write = 1'b0; acc_type = '0; alt_master = 1'b0;
    for (int c = 0; c < 8; c++) begin mdl_base[c] = '0; mdl_mask[c] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: all words clear after reset
    for (int c = 0; c < 8; c++) begin
      read_check("R1 base reset", c, 1'b0, 32'h0);
      read_check("R1 mask reset", c, 1'b1, 32'h0);
    end

    // R10: channel 0 catches everything while not enabled
    sweep("R10 global boot select", 1'b1);

    // R3: reserved bits dropped on write, read back as zero
    cfg_write(3, 1'b1, 32'hFFFF_FFFE);
    read_check("R3 mask reserved bits", 3, 1'b1, 32'hFFFF_017E);
    cfg_write(3, 1'b0, 32'hFFFF_FFFF);
    read_check("R3 base low half", 3, 1'b0, 32'hFFFF_0000);
    cfg_write(3, 1'b1, 32'h0);
    cfg_write(3, 1'b0, 32'h0);

    // R5 / R9: split region on channel 0, channel 1 programmed but disabled
    cfg_write(0, 1'b0, 32'h0000_0000);
    cfg_write(0, 1'b1, qual(16'h0008, 1'b0, 1'b0, 5'b00000, 1'b1));
    cfg_write(1, 1'b0, 32'h0001_0000);
    cfg_write(1, 1'b1, qual(16'h0000, 1'b0, 1'b0, 5'b00000, 1'b0));
    sweep("R5 split region", 1'b0);
    bus_addr = 32'h0008_1234; bus_write = 1'b0; acc_type = 3'd2; alt_master = 1'b0;
    #1; check("R5 upper block selects", {24'h0, cs_n}, 32'h0000_00FE);
    bus_addr = 32'h0004_0000;
    #1; check("R5 gap not selected", {24'h0, cs_n}, 32'h0000_00FF);
    bus_addr = 32'h0001_0000;
    #1; check("R9 disabled channel quiet", {24'h0, cs_n}, 32'h0000_00FF);
    cfg_write(1, 1'b1, qual(16'h0000, 1'b0, 1'b0, 5'b00000, 1'b1));
    bus_addr = 32'h0001_0000;
    #1; check("R9 enabled channel fires", {24'h0, cs_n}, 32'h0000_00FD);
    // R2: readback of a written qualifier
    read_check("R2 qualifier readback", 1, 1'b1, 32'h0000_0001);
    read_check("R2 base readback", 1, 1'b0, 32'h0001_0000);

    // R4 R6 R7 R8 R11: overlapping channels with mixed qualifiers
    cfg_write(0, 1'b1, qual(16'h0003, 1'b0, 1'b0, 5'b00000, 1'b1));
    cfg_write(1, 1'b0, 32'h0002_0000);
    cfg_write(1, 1'b1, qual(16'h000C, 1'b1, 1'b0, 5'b00000, 1'b1));
    cfg_write(2, 1'b0, 32'h0010_0000);
    cfg_write(2, 1'b1, qual(16'h000F, 1'b0, 1'b0, 5'b01010, 1'b1));
    cfg_write(3, 1'b0, 32'h0018_0000);
    cfg_write(3, 1'b1, qual(16'h0007, 1'b0, 1'b1, 5'b00001, 1'b1));
    cfg_write(4, 1'b0, 32'h0020_0000);
    cfg_write(4, 1'b1, qual(16'h001F, 1'b0, 1'b0, 5'b10100, 1'b1));
    cfg_write(5, 1'b0, 32'h0040_0000);
    cfg_write(5, 1'b1, qual(16'h0000, 1'b0, 1'b0, 5'b00000, 1'b0));
    cfg_write(6, 1'b0, 32'h0040_0000);
    cfg_write(6, 1'b1, qual(16'h0030, 1'b1, 1'b1, 5'b00011, 1'b1));
    cfg_write(7, 1'b0, 32'h0000_0000);
    cfg_write(7, 1'b1, qual(16'hFFFF, 1'b0, 1'b0, 5'b00100, 1'b1));
    sweep("R4 R6 R7 R8 R11 mixed decode", 1'b1);

    // R6: write into protected channel 1 falls through to the catch-all
    bus_addr = 32'h0006_0000; bus_write = 1'b1; acc_type = 3'd1; alt_master = 1'b0;
    #1; check("R6 write blocked", {24'h0, cs_n}, 32'h0000_007F);
    bus_write = 1'b0;
    #1; check("R6 read allowed", {24'h0, cs_n}, 32'h0000_00FD);
    // R8: cpu-space mask still honoured for an alternate master
    bus_addr = 32'h0025_0000; acc_type = 3'd0; alt_master = 1'b1;
    #1; check("R8 cpu space still masked", {24'h0, cs_n}, 32'h0000_007F);
    acc_type = 3'd2;
    #1; check("R8 data mask overridden", {24'h0, cs_n}, 32'h0000_00EF);

    // R10: clearing channel 0 enable restores the global select
    cfg_write(0, 1'b1, qual(16'h0003, 1'b0, 1'b0, 5'b00000, 1'b0));
    sweep("R10 global after clear", 1'b0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule